// File: doc/BRIEF.md
# Idle Mode Power Controller

This block runs the single low-power idle state of a small 8-bit microcontroller. Software writes a power-control register. When a write sets the idle-request bit, the controller waits for the next machine-cycle boundary and then enters idle. In idle it removes the registered clock enables from the CPU and from the peripheral groups: PWM, tuning PWM, ADC, I2C and on-screen display. The timers, the external interrupt inputs and the watchdog are not gated by this block, so they keep running.

While idle, the controller watches two groups of interrupt sources. The wake group covers external interrupts 0 and 1 and timers 0 and 1. Any enabled request from this group ends idle. The other group covers I2C, vertical sync and six port-pin interrupts. A source in this group can end idle only if it was already pending and enabled at the moment idle began. A new event from this group during idle is masked. A watchdog overflow, or an external reset held for enough machine cycles, also ends idle and clears the register. During idle the PWM, tuning PWM, I2C and video output pins are forced to their idle levels.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: After reset, the power-control register reads 0x00, `idle_o` and `wake_o` are 0, every clock enable is 1, and all pin outputs follow their inputs.
- R2: A register write with bit 0 set enters idle. `idle_o` rises on the first clock edge at which a machine-cycle tick is present after the write, so it rises within MC_CLKS+1 cycles of the write. The same write loads general flag 0 from bit 2 and general flag 1 from bit 3. The register reads back {4'b0, gf1, gf0, 1'b0, idle}.
- R3: `cpu_ce_o` and every bit of `per_ce_o` drop one cycle after `idle_o` rises, and return one cycle after `idle_o` falls.
- R4: During idle, a request `wk_req_i[k]` with `wk_en_i[k]` set ends idle at the next edge. The bits are k=0 external 0, k=1 external 1, k=2 timer 0 and k=3 timer 1. In the first cycle after the idle bit clears, `wake_o` is high for exactly one cycle. A request whose enable is 0 has no effect.
- R5: A request from the other group whose `oth_pend_i` and `oth_en_i` bits are both set at idle entry ends idle, with the same `wake_o` pulse.
- R6: An other-group request that first appears during idle does not end idle.
- R7: An external reset held for RST_MC machine-cycle ticks clears idle and the register, and asserts `sfr_rst_o`. A shorter pulse, spanning fewer ticks, has no effect.
- R8: A watchdog overflow clears idle and the register at the next edge and asserts `sfr_rst_o` for that cycle. It produces no `wake_o`.
- R9: While idle, `pwm_o` and `tpwm_o` are 0 and both `i2c_o` lines are 1.
- R10: While idle, all four video pins {R,G,B,blank} are driven to the inverse of `osd_bp_i`.
- R11: The general flags keep their values across idle and across an interrupt wake. After an interrupt wake, bit 0 reads 0.
- R12: Register writes made during idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pcon_wr_i | input | 1 | Power-control register write strobe |
| pcon_wdata_i | input | 8 | Register write data |
| pcon_rdata_o | output | 8 | Register read value |
| wk_req_i | input | 4 | Wake-group requests (ext0, ext1, tmr0, tmr1) |
| wk_en_i | input | 4 | Wake-group enables |
| oth_pend_i | input | N_OTH | Other-group pending requests |
| oth_en_i | input | N_OTH | Other-group enables |
| ext_rst_i | input | 1 | External reset pin, active high |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| osd_bp_i | input | 1 | OSD background polarity control bit |
| pwm_i | input | N_PWM | PWM channel outputs from the PWM unit |
| tpwm_i | input | 1 | Tuning PWM output from its unit |
| i2c_i | input | 2 | I2C output drivers from the bus unit |
| vid_i | input | 4 | R, G, B, fast-blank from the OSD |
| idle_o | output | 1 | Idle state |
| wake_o | output | 1 | One-cycle wake pulse to the CPU |
| cpu_ce_o | output | 1 | CPU clock enable |
| per_ce_o | output | 5 | Enables: PWM, tuning PWM, ADC, I2C, OSD |
| sfr_rst_o | output | 1 | Special-function-register reset |
| pwm_o | output | N_PWM | PWM pins |
| tpwm_o | output | 1 | Tuning PWM pin |
| i2c_o | output | 2 | I2C output pins |
| vid_o | output | 4 | Video pins |

## Verification
The assertions check five relations on every cycle: the one-cycle lag of the clock enables behind the idle state, idle entry aligned to a machine-cycle tick, the shape of the wake pulse, the forced pin levels in idle, and the clearing effect of a watchdog overflow. Some behaviours depend on stimulus history, and only the directed scenarios show them. These are the masking of other-group events that arrive after entry, the wake from a request that was pending at entry, the difference between a short and a long external reset, the ignoring of writes during idle, and the retention of the general flags across a wake.

// File: rtl/idle_pkg.sv
package idle_pkg;
  localparam int NWK       = 4;
  localparam int NPER      = 5;
  localparam int BIT_IDL   = 0;
  localparam int BIT_GF0   = 2;
  localparam int BIT_GF1   = 3;

  typedef enum logic [2:0] {
    GRP_PWM  = 3'd0,
    GRP_TPWM = 3'd1,
    GRP_ADC  = 3'd2,
    GRP_I2C  = 3'd3,
    GRP_OSD  = 3'd4
  } per_grp_e;

  function automatic logic wake_hit(input logic [NWK-1:0] req,
                                    input logic [NWK-1:0] en,
                                    input logic           held_any);
    return (|(req & en)) | held_any;
  endfunction

  function automatic logic [3:0] video_idle(input logic bp);
    return {4{~bp}};
  endfunction

  function automatic logic [7:0] pcon_pack(input logic idl, input logic gf0, input logic gf1);
    logic [7:0] v;
    v = 8'h00;
    v[BIT_IDL] = idl;
    v[BIT_GF0] = gf0;
    v[BIT_GF1] = gf1;
    return v;
  endfunction
endpackage

// File: rtl/idle_mc_timer.sv
module idle_mc_timer #(
  parameter int MC_CLKS = 12,
  parameter int RST_MC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_rst_i,
  output logic mc_tick_o,
  output logic ext_done_o
);
  localparam int CW = (MC_CLKS > 1) ? $clog2(MC_CLKS) : 1;
  localparam int RW = $clog2(RST_MC + 1);

  logic [CW-1:0] mc_cnt_q;
  logic [RW-1:0] ext_cnt_q;

  assign mc_tick_o = (mc_cnt_q == CW'(MC_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mc_cnt_q <= '0;
    else if (mc_tick_o) mc_cnt_q <= '0;
    else                mc_cnt_q <= mc_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       ext_cnt_q <= '0;
    else if (!ext_rst_i)                              ext_cnt_q <= '0;
    else if (mc_tick_o && ext_cnt_q != RW'(RST_MC))   ext_cnt_q <= ext_cnt_q + 1'b1;
  end

  assign ext_done_o = ext_rst_i && (ext_cnt_q == RW'(RST_MC));
endmodule

// File: rtl/idle_core.sv
module idle_core
  import idle_pkg::*;
#(
  parameter int N_OTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_tick_i,
  input  logic             hw_clr_i,
  input  logic             pcon_wr_i,
  input  logic [7:0]       pcon_wdata_i,
  input  logic [NWK-1:0]   wk_req_i,
  input  logic [NWK-1:0]   wk_en_i,
  input  logic [N_OTH-1:0] oth_pend_i,
  input  logic [N_OTH-1:0] oth_en_i,
  output logic             idle_o,
  output logic             wake_o,
  output logic [7:0]       pcon_o,
  output logic [N_OTH-1:0] snap_o,
  output logic             enter_o,
  output logic             exit_o
);
  logic             idle_q, req_q, wake_q, gf0_q, gf1_q;
  logic [N_OTH-1:0] snap_q;
  logic             wr_ok, wake_w, unused_wbits;

  assign unused_wbits = ^{pcon_wdata_i[7:4], pcon_wdata_i[1]};
  assign wr_ok   = pcon_wr_i && !idle_q && !req_q;
  assign wake_w  = wake_hit(wk_req_i, wk_en_i, |(snap_q & oth_pend_i));
  assign enter_o = !idle_q && req_q && mc_tick_i && !hw_clr_i;
  assign exit_o  = idle_q && wake_w && !hw_clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b0; req_q <= 1'b0; wake_q <= 1'b0;
      gf0_q  <= 1'b0; gf1_q <= 1'b0; snap_q <= '0;
    end else if (hw_clr_i) begin
      idle_q <= 1'b0; req_q <= 1'b0; wake_q <= 1'b0;
      gf0_q  <= 1'b0; gf1_q <= 1'b0; snap_q <= '0;
    end else begin
      wake_q <= exit_o;
      if (exit_o) begin
        idle_q <= 1'b0;
        snap_q <= '0;
      end else if (enter_o) begin
        idle_q <= 1'b1;
        req_q  <= 1'b0;
        snap_q <= oth_pend_i & oth_en_i;
      end else if (wr_ok) begin
        gf0_q <= pcon_wdata_i[BIT_GF0];
        gf1_q <= pcon_wdata_i[BIT_GF1];
        req_q <= pcon_wdata_i[BIT_IDL];
      end
    end
  end

  assign idle_o = idle_q;
  assign wake_o = wake_q;
  assign snap_o = snap_q;
  assign pcon_o = pcon_pack(idle_q | req_q, gf0_q, gf1_q);
endmodule

// File: rtl/idle_ce_gen.sv
module idle_ce_gen
  import idle_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle_i,
  output logic            cpu_ce_o,
  output logic [NPER-1:0] per_ce_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_ce_o <= 1'b1;
    else        cpu_ce_o <= !idle_i;
  end

  for (genvar g = 0; g < NPER; g++) begin : g_per
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) per_ce_o[g] <= 1'b1;
      else        per_ce_o[g] <= !idle_i;
    end
  end
endmodule

// File: rtl/idle_pin_force.sv
module idle_pin_force
  import idle_pkg::*;
#(
  parameter int N_PWM = 8
) (
  input  logic             idle_i,
  input  logic             osd_bp_i,
  input  logic [N_PWM-1:0] pwm_i,
  input  logic             tpwm_i,
  input  logic [1:0]       i2c_i,
  input  logic [3:0]       vid_i,
  output logic [N_PWM-1:0] pwm_o,
  output logic             tpwm_o,
  output logic [1:0]       i2c_o,
  output logic [3:0]       vid_o
);
  logic [3:0] vid_lvl;
  assign vid_lvl = video_idle(osd_bp_i);

  for (genvar c = 0; c < N_PWM; c++) begin : g_pwm
    assign pwm_o[c] = idle_i ? 1'b0 : pwm_i[c];
  end

  for (genvar v = 0; v < 4; v++) begin : g_vid
    assign vid_o[v] = idle_i ? vid_lvl[v] : vid_i[v];
  end

  assign tpwm_o = idle_i ? 1'b0  : tpwm_i;
  assign i2c_o  = idle_i ? 2'b11 : i2c_i;
endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl
  import idle_pkg::*;
#(
  parameter int MC_CLKS = 12,
  parameter int RST_MC  = 2,
  parameter int N_OTH   = 8,
  parameter int N_PWM   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pcon_wr_i,
  input  logic [7:0]       pcon_wdata_i,
  output logic [7:0]       pcon_rdata_o,
  input  logic [3:0]       wk_req_i,
  input  logic [3:0]       wk_en_i,
  input  logic [N_OTH-1:0] oth_pend_i,
  input  logic [N_OTH-1:0] oth_en_i,
  input  logic             ext_rst_i,
  input  logic             wdt_ovf_i,
  input  logic             osd_bp_i,
  input  logic [N_PWM-1:0] pwm_i,
  input  logic             tpwm_i,
  input  logic [1:0]       i2c_i,
  input  logic [3:0]       vid_i,
  output logic             idle_o,
  output logic             wake_o,
  output logic             cpu_ce_o,
  output logic [4:0]       per_ce_o,
  output logic             sfr_rst_o,
  output logic [N_PWM-1:0] pwm_o,
  output logic             tpwm_o,
  output logic [1:0]       i2c_o,
  output logic [3:0]       vid_o
);
  logic             mc_tick_w, ext_done_w, hw_clr_w;
  logic             enter_w, exit_w, sfr_rst_q;
  logic [N_OTH-1:0] snap_w;

  idle_mc_timer #(.MC_CLKS(MC_CLKS), .RST_MC(RST_MC)) u_mc (
    .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst_i),
    .mc_tick_o(mc_tick_w), .ext_done_o(ext_done_w)
  );

  assign hw_clr_w = ext_done_w | wdt_ovf_i;

  idle_core #(.N_OTH(N_OTH)) u_core (
    .clk(clk), .rst_n(rst_n), .mc_tick_i(mc_tick_w), .hw_clr_i(hw_clr_w),
    .pcon_wr_i(pcon_wr_i), .pcon_wdata_i(pcon_wdata_i),
    .wk_req_i(wk_req_i), .wk_en_i(wk_en_i),
    .oth_pend_i(oth_pend_i), .oth_en_i(oth_en_i),
    .idle_o(idle_o), .wake_o(wake_o), .pcon_o(pcon_rdata_o),
    .snap_o(snap_w), .enter_o(enter_w), .exit_o(exit_w)
  );

  idle_ce_gen u_ce (
    .clk(clk), .rst_n(rst_n), .idle_i(idle_o),
    .cpu_ce_o(cpu_ce_o), .per_ce_o(per_ce_o)
  );

  idle_pin_force #(.N_PWM(N_PWM)) u_pins (
    .idle_i(idle_o), .osd_bp_i(osd_bp_i),
    .pwm_i(pwm_i), .tpwm_i(tpwm_i), .i2c_i(i2c_i), .vid_i(vid_i),
    .pwm_o(pwm_o), .tpwm_o(tpwm_o), .i2c_o(i2c_o), .vid_o(vid_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sfr_rst_q <= 1'b0;
    else        sfr_rst_q <= hw_clr_w;
  end
  assign sfr_rst_o = sfr_rst_q;
endmodule

// File: rtl/idle_pwr_ctrl_chk.sv
module idle_pwr_ctrl_chk #(
  parameter int N_OTH = 8,
  parameter int N_PWM = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mc_tick_w,
  input logic             hw_clr_w,
  input logic             wdt_ovf_i,
  input logic [3:0]       wk_req_i,
  input logic [3:0]       wk_en_i,
  input logic [N_OTH-1:0] oth_pend_i,
  input logic [N_OTH-1:0] snap_w,
  input logic             osd_bp_i,
  input logic             idle_o,
  input logic             wake_o,
  input logic             cpu_ce_o,
  input logic [4:0]       per_ce_o,
  input logic             sfr_rst_o,
  input logic [7:0]       pcon_rdata_o,
  input logic [N_PWM-1:0] pwm_o,
  input logic             tpwm_o,
  input logic [1:0]       i2c_o,
  input logic [3:0]       vid_o
);
  AST_ENTRY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> $past(mc_tick_w)); // R2
  AST_CE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce_o == !$past(idle_o)); // R3
  AST_PER_CE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    per_ce_o == {5{cpu_ce_o}}); // R3
  AST_WAKE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (!idle_o && $past(idle_o))); // R4
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && !hw_clr_w && !(|(wk_req_i & wk_en_i)) && !(|(snap_w & oth_pend_i))) |=> idle_o); // R6
  AST_WDT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_ovf_i |=> (!idle_o && sfr_rst_o && pcon_rdata_o == 8'h00 && !wake_o)); // R8
  AST_PIN_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (pwm_o == '0 && !tpwm_o && i2c_o == 2'b11)); // R9
  AST_VIDEO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (vid_o == {4{!osd_bp_i}})); // R10
endmodule

bind idle_pwr_ctrl idle_pwr_ctrl_chk #(.N_OTH(N_OTH), .N_PWM(N_PWM)) u_chk (
  .clk(clk), .rst_n(rst_n), .mc_tick_w(mc_tick_w), .hw_clr_w(hw_clr_w),
  .wdt_ovf_i(wdt_ovf_i), .wk_req_i(wk_req_i), .wk_en_i(wk_en_i),
  .oth_pend_i(oth_pend_i), .snap_w(snap_w), .osd_bp_i(osd_bp_i),
  .idle_o(idle_o), .wake_o(wake_o), .cpu_ce_o(cpu_ce_o), .per_ce_o(per_ce_o),
  .sfr_rst_o(sfr_rst_o), .pcon_rdata_o(pcon_rdata_o), .pwm_o(pwm_o),
  .tpwm_o(tpwm_o), .i2c_o(i2c_o), .vid_o(vid_o)
);

// File: tb/idle_pwr_ctrl_tb.sv
module idle_pwr_ctrl_tb;
  localparam int MC  = 12;
  localparam int RMC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pcon_wr_i = 1'b0;
  logic [7:0] pcon_wdata_i = '0;
  logic [7:0] pcon_rdata_o;
  logic [3:0] wk_req_i = '0, wk_en_i = '0;
  logic [7:0] oth_pend_i = '0, oth_en_i = '0;
  logic       ext_rst_i = 1'b0, wdt_ovf_i = 1'b0, osd_bp_i = 1'b1;
  logic [7:0] pwm_i = 8'hA5;
  logic       tpwm_i = 1'b1;
  logic [1:0] i2c_i = 2'b00;
  logic [3:0] vid_i = 4'b1010;
  logic       idle_o, wake_o, cpu_ce_o, sfr_rst_o, tpwm_o;
  logic [4:0] per_ce_o;
  logic [7:0] pwm_o;
  logic [1:0] i2c_o;
  logic [3:0] vid_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  idle_pwr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pcon_wr_i(pcon_wr_i), .pcon_wdata_i(pcon_wdata_i),
    .pcon_rdata_o(pcon_rdata_o), .wk_req_i(wk_req_i), .wk_en_i(wk_en_i),
    .oth_pend_i(oth_pend_i), .oth_en_i(oth_en_i), .ext_rst_i(ext_rst_i),
    .wdt_ovf_i(wdt_ovf_i), .osd_bp_i(osd_bp_i), .pwm_i(pwm_i), .tpwm_i(tpwm_i),
    .i2c_i(i2c_i), .vid_i(vid_i), .idle_o(idle_o), .wake_o(wake_o),
    .cpu_ce_o(cpu_ce_o), .per_ce_o(per_ce_o), .sfr_rst_o(sfr_rst_o),
    .pwm_o(pwm_o), .tpwm_o(tpwm_o), .i2c_o(i2c_o), .vid_o(vid_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_pcon(input logic [7:0] d);
    pcon_wr_i = 1'b1; pcon_wdata_i = d;
    @(negedge clk);
    pcon_wr_i = 1'b0;
  endtask

  // enters idle and checks entry timing and enable lag (R2, R3)
  task automatic enter_idle(input logic [7:0] d);
    int n;
    n = 0;
    wr_pcon(d);
    while (!idle_o && n < MC + 2) begin @(negedge clk); n++; end
    chk(idle_o, "R2 idle entry within machine cycle", {31'd0, idle_o}, 1);
    chk(cpu_ce_o == 1'b1, "R3 enable still high on entry cycle", {31'd0, cpu_ce_o}, 1);
    @(negedge clk);
    chk(cpu_ce_o == 1'b0 && per_ce_o == 5'd0, "R3 enables low after entry", {26'd0, cpu_ce_o, per_ce_o}, 0);
  endtask

  task automatic t_reset;
    chk(pcon_rdata_o == 8'h00, "R1 register reset", pcon_rdata_o, 0);
    chk(!idle_o && !wake_o, "R1 idle/wake reset", {30'd0, idle_o, wake_o}, 0);
    chk(cpu_ce_o && per_ce_o == 5'h1F, "R1 enables reset", {26'd0, cpu_ce_o, per_ce_o}, 32'h3F);
    chk(pwm_o == 8'hA5 && tpwm_o && i2c_o == 2'b00 && vid_o == 4'b1010,
        "R1 pins pass through", {17'd0, pwm_o, tpwm_o, i2c_o, vid_o}, {17'd0, 8'hA5, 1'b1, 2'b00, 4'b1010});
  endtask

  task automatic t_flags;
    wr_pcon(8'h0C);
    cyc(2);
    chk(pcon_rdata_o == 8'h0C && !idle_o, "R2 flags written without idle", pcon_rdata_o, 8'h0C);
    wr_pcon(8'h00);
    chk(pcon_rdata_o == 8'h00, "R2 flags cleared", pcon_rdata_o, 0);
  endtask

  task automatic t_pins_and_wake;
    wk_en_i = 4'b0001;
    enter_idle(8'h05);
    chk(pwm_o == 8'h00 && !tpwm_o && i2c_o == 2'b11, "R9 forced pin levels",
        {21'd0, pwm_o, tpwm_o, i2c_o}, {21'd0, 8'h00, 1'b0, 2'b11});
    chk(vid_o == 4'b0000, "R10 video inverse of bp=1", vid_o, 0);
    osd_bp_i = 1'b0; #1;
    chk(vid_o == 4'b1111, "R10 video inverse of bp=0", vid_o, 4'hF);
    osd_bp_i = 1'b1;
    wr_pcon(8'h00);
    chk(idle_o && pcon_rdata_o == 8'h05, "R12 write during idle ignored", pcon_rdata_o, 8'h05);
    wk_req_i = 4'b0001;
    @(negedge clk);
    wk_req_i = 4'b0000;
    chk(!idle_o && wake_o && !cpu_ce_o, "R4 wake pulse on exit cycle", {29'd0, idle_o, wake_o, cpu_ce_o}, 32'b010);
    @(negedge clk);
    chk(!wake_o && cpu_ce_o && per_ce_o == 5'h1F, "R3 enables restored, R4 pulse single",
        {26'd0, wake_o, per_ce_o}, 32'h1F);
    chk(pcon_rdata_o == 8'h04, "R11 flags kept, idle bit cleared", pcon_rdata_o, 8'h04);
    chk(pwm_o == 8'hA5 && vid_o == 4'b1010, "R9 pins released", {24'd0, pwm_o}, 8'hA5);
  endtask

  task automatic t_disabled_then_masked;
    wk_en_i = 4'b0000;
    oth_en_i = 8'hFF;
    enter_idle(8'h09);
    wk_req_i = 4'b0100;
    oth_pend_i = 8'h08;
    cyc(6);
    chk(idle_o && !wake_o, "R4 disabled request ignored", {30'd0, idle_o, wake_o}, 32'b10);
    chk(idle_o && !cpu_ce_o, "R6 new other-group request masked", {30'd0, idle_o, cpu_ce_o}, 32'b10);
    oth_pend_i = 8'h00;
    wk_req_i = 4'b1000; wk_en_i = 4'b1000;
    @(negedge clk);
    wk_req_i = 4'b0000;
    chk(!idle_o && wake_o, "R4 timer1 wake", {30'd0, idle_o, wake_o}, 32'b01);
    chk(pcon_rdata_o == 8'h08, "R11 gf1 kept across idle", pcon_rdata_o, 8'h08);
    cyc(1);
  endtask

  task automatic t_pending_other;
    wk_en_i = 4'b0000;
    oth_en_i = 8'hFF;
    oth_pend_i = 8'h02;
    enter_idle(8'h01);
    chk(!idle_o && wake_o, "R5 pending other-group wake", {30'd0, idle_o, wake_o}, 32'b01);
    oth_pend_i = 8'h00;
    cyc(2);
    chk(cpu_ce_o && !idle_o, "R5 running after wake", {30'd0, cpu_ce_o, idle_o}, 32'b10);
  endtask

  task automatic t_ext_reset;
    enter_idle(8'h0D);
    ext_rst_i = 1'b1;
    cyc(3);
    ext_rst_i = 1'b0;
    cyc(2);
    chk(idle_o && pcon_rdata_o == 8'h0D && !sfr_rst_o, "R7 short reset ignored", pcon_rdata_o, 8'h0D);
    ext_rst_i = 1'b1;
    cyc((RMC + 1) * MC);
    chk(!idle_o && pcon_rdata_o == 8'h00 && sfr_rst_o, "R7 long reset clears",
        {23'd0, idle_o, pcon_rdata_o}, 0);
    ext_rst_i = 1'b0;
    cyc(2);
    chk(!sfr_rst_o && !idle_o, "R7 reset released", {30'd0, sfr_rst_o, idle_o}, 0);
  endtask

  task automatic t_wdt;
    enter_idle(8'h05);
    wdt_ovf_i = 1'b1;
    @(negedge clk);
    wdt_ovf_i = 1'b0;
    chk(!idle_o && sfr_rst_o && !wake_o && pcon_rdata_o == 8'h00, "R8 watchdog clears idle",
        {21'd0, idle_o, sfr_rst_o, wake_o, pcon_rdata_o}, 32'h200);
    @(negedge clk);
    chk(!sfr_rst_o && cpu_ce_o, "R8 reset pulse ends", {30'd0, sfr_rst_o, cpu_ce_o}, 32'b01);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_flags();
    t_pins_and_wake();
    t_disabled_then_masked();
    t_pending_other();
    t_ext_reset();
    t_wdt();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule